// File: doc/BRIEF.md
# Event and Divider Timer (8-bit)

An 8-bit up-counter compared against a writable match register, running in one of two modes. In event mode it counts falling edges of an external signal. The signal is first brought into the clock domain by a synchronizer. In divide mode it counts a single-cycle internal clock enable. On each match it inverts a timer flip-flop, and the output pin drives the inverse of that flip-flop, so the pin carries a square wave with 50% duty.

Every match raises a one-cycle interrupt pulse and returns the counter to zero. The match register has no shadow copy, so a new value applies at the next compare. Software can preset the timer flip-flop in divide mode. When the timer is stopped the counter is held at zero.

Top module: `evt_div_timer`

## Requirements
- R1: After reset `irq_o` is 0 and `div_o` is 1, because the timer flip-flop resets to 0.
- R2: In event mode (`mode_i`=0) with `run_i`=1, the counter increments on each falling edge of `evt_i`. Each level of `evt_i` must be held for at least two clock cycles. With match value n, one interrupt is raised every n+1 falling edges.
- R3: Each match gives a single-cycle `irq_o` pulse and clears the counter to 0. An interrupt is raised only while `run_i` is 1.
- R4: A match-register write (`cmp_we_i`) takes effect at the next compare, with no shadow copy. With the count at 3, lowering the match value from 10 to 5 gives an interrupt on the third edge after the write.
- R5: In divide mode (`mode_i`=1) with `run_i`=1, the counter advances on each cycle with `tick_i`=1. Each match inverts the timer flip-flop, so `div_o` has a period of 2(n+1) ticks.
- R6: `div_o` is always the inverse of the timer flip-flop.
- R7: In divide mode, `tff_we_i` loads `tff_wdata_i` into the timer flip-flop. In event mode the flip-flop is forced to 0, so `div_o` stays 1 and preset writes have no effect.
- R8: While `run_i` is 0 the counter is held at 0, no interrupt is raised and the timer flip-flop keeps its value. After a restart, counting begins again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: event count, 1: divide output |
| run_i | input | 1 | 1 runs the timer, 0 stops it and clears the counter |
| cmp_we_i | input | 1 | Match-register write strobe |
| cmp_wdata_i | input | 8 | Match-register write value |
| tff_we_i | input | 1 | Timer flip-flop preset strobe |
| tff_wdata_i | input | 1 | Timer flip-flop preset value |
| evt_i | input | 1 | External event input (asynchronous) |
| tick_i | input | 1 | Internal count enable for divide mode |
| div_o | output | 1 | Divider output, the inverse of the timer flip-flop |
| irq_o | output | 1 | Match interrupt pulse |

## Verification
The assertions assume that `mode_i` changes only while the timer is stopped. They also assume that a preset write is the only way the flip-flop can change, other than a match. The bench changes the mode only with `run_i` low, and it issues presets only between runs. In event runs, every level of `evt_i` is held for two to four cycles. The input is also held high for several cycles before the timer starts and after it stops, so that no edge is still in the synchronizer when `run_i` changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    TM_EVENT  = 1'b0,
    TM_DIVIDE = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/evt_fall_det.sv
module evt_fall_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= evt_i;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  // falling edge: previous sample high, current sample low
  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic             match_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CmpRst = '1;

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             hit, irq_q;

  assign hit     = (cnt_q == cmp_q);
  assign match_o = run_i & step_i & hit;

  // unbuffered match register: new value is seen by the next compare
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= CmpRst;
    else if (cmp_we_i) cmp_q <= cmp_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (step_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= match_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_tff.sv
module tmr_tff
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tmr_mode_e mode_i,
  input  logic      toggle_i,
  input  logic      preset_we_i,
  input  logic      preset_val_i,
  output logic      tff_o
);
  logic tff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tff_q <= 1'b0;
    else if (mode_i == TM_EVENT) tff_q <= 1'b0;
    else if (preset_we_i)        tff_q <= preset_val_i;
    else if (toggle_i)           tff_q <= ~tff_q;
  end

  assign tff_o = tff_q;
endmodule

// File: rtl/evt_div_timer.sv
module evt_div_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             run_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             tff_we_i,
  input  logic             tff_wdata_i,
  input  logic             evt_i,
  input  logic             tick_i,
  output logic             div_o,
  output logic             irq_o
);
  tmr_mode_e mode;
  logic      evt_fall, step, match, tff;

  assign mode = tmr_mode_e'(mode_i);

  evt_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .fall_o (evt_fall)
  );

  assign step = (mode == TM_EVENT) ? evt_fall : tick_i;

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .step_i      (step),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .match_o     (match),
    .irq_o       (irq_o)
  );

  tmr_tff u_tff (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .toggle_i     (match),
    .preset_we_i  (tff_we_i),
    .preset_val_i (tff_wdata_i),
    .tff_o        (tff)
  );

  assign div_o = ~tff;
endmodule

// File: rtl/evt_div_timer_chk.sv
module evt_div_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_i,
  input logic run_i,
  input logic tff_we_i,
  input logic div_o,
  input logic irq_o
);
  // R3: an interrupt follows a cycle in which the timer ran
  a_r3_irq_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(run_i));

  // R7: event mode forces the flip-flop low, so the pin is high
  a_r7_event_div_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> div_o);

  // R8: a stopped timer with no preset keeps its output level
  a_r8_stop_holds_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && mode_i && !tff_we_i) |=> $stable(div_o));

  // R5: in divide mode, a change on the pin with no preset comes with a match interrupt
  a_r5_toggle_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $past(mode_i) && !$past(tff_we_i) && !$stable(div_o)) |-> irq_o);
endmodule

bind evt_div_timer evt_div_timer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .run_i    (run_i),
  .tff_we_i (tff_we_i),
  .div_o    (div_o),
  .irq_o    (irq_o)
);

// File: tb/sim_evt_div_timer.sv
`timescale 1ns/1ps
module sim_evt_div_timer;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       mode_i = 1'b0, run_i = 1'b0, cmp_we_i = 1'b0, tff_we_i = 1'b0, tff_wdata_i = 1'b0;
  logic [7:0] cmp_wdata_i = '0;
  logic       evt_i = 1'b1, tick_i = 1'b0;
  logic       div_o, irq_o;

  int total = 0, fails = 0;
  int irq_cnt = 0, tog_cnt = 0, exp_ticks = 0;
  logic last_div = 1'b1;

  always #4 clk = ~clk;  // 125 MHz

  evt_div_timer u0 (.clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .run_i(run_i),
    .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i), .tff_we_i(tff_we_i),
    .tff_wdata_i(tff_wdata_i), .evt_i(evt_i), .tick_i(tick_i), .div_o(div_o), .irq_o(irq_o));

  always @(negedge clk) begin
    if (irq_o) irq_cnt++;
    if (div_o !== last_div) tog_cnt++;
    last_div = div_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_matches(input int steps, input int n);
    return steps / (n + 1);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_mon();
    @(negedge clk);
    irq_cnt = 0; tog_cnt = 0; exp_ticks = 0; last_div = div_o;
  endtask

  task automatic wr_cmp(input int v);
    @(negedge clk); cmp_we_i = 1'b1; cmp_wdata_i = v[7:0];
    @(negedge clk); cmp_we_i = 1'b0;
  endtask

  task automatic wr_tff(input bit v);
    @(negedge clk); tff_we_i = 1'b1; tff_wdata_i = v;
    @(negedge clk); tff_we_i = 1'b0;
  endtask

  task automatic falls(input int k);
    for (int i = 0; i < k; i++) begin
      evt_i = 1'b0; idle(2 + int'($urandom_range(2)));
      evt_i = 1'b1; idle(2 + int'($urandom_range(2)));
    end
    idle(6);
  endtask

  task automatic ticks(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = rnd ? 1'($urandom_range(1)) : 1'b1;
      if (run_i && tick_i) exp_ticks++;
    end
    @(negedge clk); tick_i = 1'b0;
    idle(3);
  endtask

  task automatic event_run(input int n, input int k);
    @(negedge clk); run_i = 1'b0; mode_i = 1'b0; evt_i = 1'b1;
    wr_cmp(n); idle(6);
    clr_mon();
    run_i = 1'b1;
    falls(k);
    chk(irq_cnt == exp_matches(k, n), "R2 event irq count", irq_cnt, exp_matches(k, n));
    chk(tog_cnt == 0 && div_o == 1'b1, "R7 event div_o constant high", int'(div_o), 1);
    @(negedge clk); run_i = 1'b0;
  endtask

  task automatic div_run(input int n, input bit p, input int cyc, input bit rnd);
    int m;
    @(negedge clk); run_i = 1'b0; mode_i = 1'b1; tick_i = 1'b0;
    wr_cmp(n); wr_tff(p); idle(1);
    chk(div_o == !p, "R6 div_o inverse of preset", int'(div_o), int'(!p));
    clr_mon();
    run_i = 1'b1;
    ticks(cyc, rnd);
    m = exp_matches(exp_ticks, n);
    chk(irq_cnt == m, "R5 divide irq count", irq_cnt, m);
    chk(tog_cnt == m, "R5 divide toggle count", tog_cnt, m);
    chk(div_o == !(p ^ m[0]), "R5 R6 divide final level", int'(div_o), int'(!(p ^ m[0])));
    @(negedge clk); run_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle(3);
    chk(irq_o == 1'b0, "R1 reset irq_o", int'(irq_o), 0);
    chk(div_o == 1'b1, "R1 reset div_o", int'(div_o), 1);
    @(negedge clk); rst_ni = 1'b1;
    idle(2);

    // R3 R2: compare 0 matches on every edge; compare 3 on every fourth
    event_run(0, 5);
    event_run(3, 9);

    // R4: lower match value mid-count (count 3, 10 -> 5): third edge matches
    @(negedge clk); mode_i = 1'b0; evt_i = 1'b1; wr_cmp(10); idle(6);
    clr_mon(); run_i = 1'b1;
    falls(3); wr_cmp(5); falls(2);
    chk(irq_cnt == 0, "R4 no match before new value reached", irq_cnt, 0);
    falls(1);
    chk(irq_cnt == 1, "R4 new match value used at once", irq_cnt, 1);
    @(negedge clk); run_i = 1'b0;

    // R7: preset ignored in event mode
    wr_tff(1'b1); idle(2);
    chk(div_o == 1'b1, "R7 preset ignored in event mode", int'(div_o), 1);

    // R5: compare 0 gives period 2; compare 255 gives period 512
    div_run(0, 1'b0, 20, 1'b0);
    div_run(255, 1'b1, 600, 1'b0);

    // R8: stopped timer ignores ticks
    @(negedge clk); mode_i = 1'b1; run_i = 1'b0; wr_cmp(2); wr_tff(1'b1); idle(1);
    clr_mon(); ticks(40, 1'b0);
    chk(irq_cnt == 0, "R8 no irq while stopped", irq_cnt, 0);
    chk(tog_cnt == 0 && div_o == 1'b0, "R8 flip-flop held while stopped", int'(div_o), 0);

    // R8: restart counts from 0 (compare 3: 3 ticks, stop, restart, 3 ticks, no match)
    wr_cmp(3); clr_mon();
    run_i = 1'b1; ticks(3, 1'b0);
    @(negedge clk); run_i = 1'b0; @(negedge clk); run_i = 1'b1;
    ticks(3, 1'b0);
    chk(irq_cnt == 0, "R8 counter cleared by stop", irq_cnt, 0);
    ticks(1, 1'b0);
    chk(irq_cnt == 1, "R8 R3 match after n+1 ticks from restart", irq_cnt, 1);
    @(negedge clk); run_i = 1'b0;

    // random mix
    for (int i = 0; i < 4; i++)
      event_run(int'($urandom_range(6)), 3 + int'($urandom_range(20)));
    for (int i = 0; i < 6; i++)
      div_run(int'($urandom_range(15)), 1'($urandom_range(1)), 100 + int'($urandom_range(200)), 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule